// File: doc/BRIEF.md
# Tree Switch Route Decision Unit

This unit sits in one switch of a k-ary tree network, where k is a power of two. Every leaf has an address made of d radix-k digits. The most significant digit is the branch taken at the root and the least significant digit is the branch taken just above the leaf. Each switch is told its own level: level 1 is the switch directly above the leaves, and level d is the root. For each packet header, the unit decides where the packet goes next. It can go up to the parent, down through one of k child ports, or out to the local delivery port.

The decision is computed, not looked up. The unit XORs the source and destination addresses. The highest radix-k digit that differs, at digit index m, means the packet must climb m+1 levels to the common ancestor. A header arriving from below at a switch whose level is below m+1 keeps climbing. At or above that level, the header turns down and takes the child given by destination digit level-1. A header arriving from the parent is already descending, so it always takes that destination digit. A header from below whose source equals its destination goes to the local port.

Headers enter through a valid/ready handshake. The one-hot port choice comes out of a register one cycle later and is held until the consumer accepts it. A two-state controller governs the holding register:
- **EMPTY**: the register holds nothing. It takes the transition **load** to FULL when a header is accepted.
- **FULL**: the register holds a decision. It takes the transition **drain** back to EMPTY when the decision is accepted and no new header arrives. It takes the transition **swap** (stay FULL) when the decision is accepted and a new header is accepted in the same cycle.
- While FULL and not drained, the controller makes no transition (**stall**).

Top module: `tree_route_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `hdr_ready` is 1.
- R2: A header from a child (`hdr_from_parent`=0) whose source equals its destination selects the local port, `out_port` bit 0.
- R3: A header from a child whose level is less than m+1 selects the parent port, `out_port` bit 1. Here m is the index of the most significant nonzero radix-k digit of source XOR destination, and digit j occupies address bits [j·log2(k) +: log2(k)].
- R4: A header from a child whose level is m+1 or greater selects child port c, `out_port` bit 2+c, where c is destination digit level-1.
- R5: A header from the parent (`hdr_from_parent`=1) selects child port c = destination digit level-1, `out_port` bit 2+c, whatever the source address is.
- R6: While `out_valid` is 1, `out_port` has exactly one bit set. Its width is k+2.
- R7: A header accepted on a clock edge (`hdr_valid` and `hdr_ready` both high) makes `out_valid` 1 after that edge, with its decision on `out_port`.
- R8: While `out_valid` is 1 and `out_ready` is 0, `hdr_ready` is 0, and `out_port` and `out_valid` hold their values. A header offered during the stall does not disturb them.
- R9: While `out_ready` is 1, `hdr_ready` is 1. A decision is drained and a new header loaded on the same edge, with no gap cycle.
- R10: After a drain with no new header accepted, `out_valid` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Header can be taken |
| hdr_level | input | clog2(D+1) | Level of this switch, 1 (above leaves) to D (root) |
| hdr_from_parent | input | 1 | Header arrived through the parent port |
| hdr_src | input | D·log2(K) | Source leaf address |
| hdr_dst | input | D·log2(K) | Destination leaf address |
| out_valid | output | 1 | Decision held in register |
| out_ready | input | 1 | Consumer takes the decision |
| out_port | output | K+2 | One-hot: bit 0 local, bit 1 parent, bit 2+c child c |

## Verification
The bench looks for the turning point in the tree. It uses headers whose first differing digit lies at the lowest, a middle and the root position, and presents the same header at successive levels. A design that counts the climb off by one would send such a header down one level too early, or up from the root. It also probes the digit-index choice. A design that reads destination digit `level` instead of `level-1` would pick the wrong child, which shows up as a different one-hot bit. Descending headers with a source equal to or unrelated to the destination catch a design that lets the source address influence a header arriving from the parent. Stalled-output tests with a competing header catch a register that is overwritten under back-pressure, or a unit that inserts a bubble when the output drains and a new header loads on the same edge.

// File: rtl/tree_route_pkg.sv
package tree_route_pkg;

    // holding-register controller states
    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } hold_state_t;

    // fixed positions in the one-hot port vector
    localparam int PORT_LOCAL  = 0;
    localparam int PORT_PARENT = 1;
    localparam int PORT_CHILD0 = 2;

endpackage

// File: rtl/tree_route_span.sv
// Finds how many levels a header must climb: one more than the index of the
// highest radix-K digit in which source and destination differ.
module tree_route_span #(
    parameter int K = 4,
    parameter int D = 3
) (
    input  logic [D*$clog2(K)-1:0] src,
    input  logic [D*$clog2(K)-1:0] dst,
    output logic                   same,
    output logic [$clog2(D+1)-1:0] climb
);
    localparam int LK = $clog2(K);
    localparam int AW = D * LK;
    localparam int LW = $clog2(D + 1);

    logic [AW-1:0] diff;
    logic [D-1:0]  digit_nz;

    assign diff = src ^ dst;

    generate
        for (genvar j = 0; j < D; j++) begin : g_digit
            assign digit_nz[j] = |diff[j*LK +: LK];
        end
    endgenerate

    always_comb begin
        climb = '0;
        for (int j = 0; j < D; j++) begin
            if (digit_nz[j]) begin
                climb = LW'(j + 1);
            end
        end
    end

    assign same = ~|digit_nz;

endmodule

// File: rtl/tree_route_pick.sv
// Turns climb count, level and arrival direction into a one-hot port choice.
module tree_route_pick
    import tree_route_pkg::*;
#(
    parameter int K = 4,
    parameter int D = 3
) (
    input  logic [$clog2(D+1)-1:0] level,
    input  logic                   from_parent,
    input  logic [D*$clog2(K)-1:0] dst,
    input  logic                   same,
    input  logic [$clog2(D+1)-1:0] climb,
    output logic [K+1:0]           port
);
    localparam int LK = $clog2(K);
    localparam int LW = $clog2(D + 1);
    localparam int PW = K + 2;

    logic [LK-1:0] dst_digit [D];
    logic [LK-1:0] down_sel;
    logic [K-1:0]  child_hot;
    logic          go_up;

    generate
        for (genvar j = 0; j < D; j++) begin : g_split
            assign dst_digit[j] = dst[j*LK +: LK];
        end
    endgenerate

    // destination digit at index level-1
    always_comb begin
        down_sel = '0;
        for (int j = 0; j < D; j++) begin
            if (level == LW'(j + 1)) begin
                down_sel = dst_digit[j];
            end
        end
    end

    generate
        for (genvar c = 0; c < K; c++) begin : g_child
            assign child_hot[c] = (down_sel == LK'(c));
        end
    endgenerate

    assign go_up = (level < climb);

    always_comb begin
        port = '0;
        if (from_parent) begin
            port[PW-1:PORT_CHILD0] = child_hot;
        end else if (same) begin
            port[PORT_LOCAL] = 1'b1;
        end else if (go_up) begin
            port[PORT_PARENT] = 1'b1;
        end else begin
            port[PW-1:PORT_CHILD0] = child_hot;
        end
    end

endmodule

// File: rtl/tree_route_ctrl.sv
// Two-state controller for the single decision register.
module tree_route_ctrl
    import tree_route_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    input  logic out_ready,
    output logic out_valid,
    output logic load
);
    hold_state_t state_q;
    hold_state_t state_d;

    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b1;
        out_valid = 1'b0;
        load      = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                in_ready = 1'b1;
                load     = in_valid;
                if (in_valid) begin
                    state_d = ST_FULL;              // load
                end
            end
            ST_FULL: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
                load      = out_ready && in_valid;
                if (out_ready && !in_valid) begin
                    state_d = ST_EMPTY;             // drain
                end else begin
                    state_d = ST_FULL;              // swap or stall
                end
            end
            default: begin
                state_d = ST_EMPTY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/tree_route_unit.sv
module tree_route_unit #(
    parameter int K = 4,
    parameter int D = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hdr_valid,
    output logic                   hdr_ready,
    input  logic [$clog2(D+1)-1:0] hdr_level,
    input  logic                   hdr_from_parent,
    input  logic [D*$clog2(K)-1:0] hdr_src,
    input  logic [D*$clog2(K)-1:0] hdr_dst,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [K+1:0]           out_port
);
    localparam int LW = $clog2(D + 1);
    localparam int PW = K + 2;

    logic          same;
    logic [LW-1:0] climb;
    logic [PW-1:0] port_d;
    logic [PW-1:0] port_q;
    logic          load;

    tree_route_span #(.K(K), .D(D)) u_span (
        .src   (hdr_src),
        .dst   (hdr_dst),
        .same  (same),
        .climb (climb)
    );

    tree_route_pick #(.K(K), .D(D)) u_pick (
        .level       (hdr_level),
        .from_parent (hdr_from_parent),
        .dst         (hdr_dst),
        .same        (same),
        .climb       (climb),
        .port        (port_d)
    );

    tree_route_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (hdr_valid),
        .in_ready  (hdr_ready),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .load      (load)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
        end else if (load) begin
            port_q <= port_d;
        end
    end

    assign out_port = port_q;

endmodule

// File: rtl/tree_route_unit_chk.sv
module tree_route_unit_chk #(
    parameter int K = 4,
    parameter int D = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         hdr_valid,
    input logic         hdr_ready,
    input logic         out_valid,
    input logic         out_ready,
    input logic [K+1:0] out_port
);
    // R6
    a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(out_port) == 1);

    // R7
    a_r7_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready) |=> out_valid);

    // R8
    a_r8_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !hdr_ready);

    // R8
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_port)));

    // R9
    a_r9_ready_on_drain: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> hdr_ready);

    // R10
    a_r10_empty_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !hdr_valid) |=> !out_valid);

endmodule

bind tree_route_unit tree_route_unit_chk #(.K(K), .D(D)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_valid (hdr_valid),
    .hdr_ready (hdr_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_port  (out_port)
);

// File: tb/tree_route_unit_test.sv
module tree_route_unit_test;
    localparam int K  = 4;
    localparam int D  = 3;
    localparam int LW = 2;
    localparam int AW = 6;
    localparam int PW = 6;
    localparam int NV = 14;

    typedef struct packed {
        logic [LW-1:0] level;
        logic          fp;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [PW-1:0] exp;
        logic [3:0]    req;
    } vec_t;

    // port bits: 0 local, 1 parent, 2+c child c; digit j = address bits [2j+1:2j]
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b0, 6'b000101, 6'b000101, 6'b000001, 4'd2},  // R2 equal
        '{2'd3, 1'b0, 6'b101010, 6'b101010, 6'b000001, 4'd2},  // R2 equal at root
        '{2'd1, 1'b0, 6'b000100, 6'b000111, 6'b100000, 4'd4},  // R4 m=0
        '{2'd1, 1'b0, 6'b000100, 6'b001001, 6'b000010, 4'd3},  // R3 m=1
        '{2'd2, 1'b0, 6'b000100, 6'b001001, 6'b010000, 4'd4},  // R4 turn
        '{2'd1, 1'b0, 6'b000000, 6'b110000, 6'b000010, 4'd3},  // R3 m=2
        '{2'd2, 1'b0, 6'b000000, 6'b110000, 6'b000010, 4'd3},  // R3 m=2
        '{2'd3, 1'b0, 6'b000000, 6'b110000, 6'b100000, 4'd4},  // R4 root turn
        '{2'd1, 1'b1, 6'b110000, 6'b000010, 6'b010000, 4'd5},  // R5
        '{2'd2, 1'b1, 6'b110000, 6'b011100, 6'b100000, 4'd5},  // R5
        '{2'd1, 1'b0, 6'b111111, 6'b111110, 6'b010000, 4'd4},  // R4
        '{2'd3, 1'b0, 6'b000000, 6'b100000, 6'b010000, 4'd4},  // R4
        '{2'd1, 1'b1, 6'b000001, 6'b000001, 6'b001000, 4'd5},  // R5 src ignored
        '{2'd3, 1'b1, 6'b000000, 6'b010000, 6'b001000, 4'd5}   // R5 root down
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hdr_valid = 1'b0;
    logic          hdr_ready;
    logic [LW-1:0] hdr_level = '0;
    logic          hdr_from_parent = 1'b0;
    logic [AW-1:0] hdr_src = '0;
    logic [AW-1:0] hdr_dst = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [PW-1:0] out_port;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tree_route_unit #(.K(K), .D(D)) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .hdr_valid       (hdr_valid),
        .hdr_ready       (hdr_ready),
        .hdr_level       (hdr_level),
        .hdr_from_parent (hdr_from_parent),
        .hdr_src         (hdr_src),
        .hdr_dst         (hdr_dst),
        .out_valid       (out_valid),
        .out_ready       (out_ready),
        .out_port        (out_port)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_hdr(input vec_t v);
        hdr_level       = v.level;
        hdr_from_parent = v.fp;
        hdr_src         = v.src;
        hdr_dst         = v.dst;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
        check(hdr_ready == 1'b1, "R1 hdr_ready", 32'(hdr_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: one header per cycle, output always ready (R7, R9 back-to-back)
        for (int i = 0; i < NV; i++) begin
            put_hdr(VECS[i]);
            hdr_valid = 1'b1;
            out_ready = 1'b1;
            @(posedge clk);
            #1;
            check(out_valid == 1'b1, "R7 valid after accept", 32'(out_valid), 32'd1);
            check(out_port == VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i),
                  32'(out_port), 32'(VECS[i].exp));
            @(negedge clk);
        end

        // R10 drain with nothing new
        hdr_valid = 1'b0;
        @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R10 empty after drain", 32'(out_valid), 32'd0);

        // R8 stall: load A, hold output, offer B
        @(negedge clk);
        put_hdr(VECS[3]);        // parent port
        hdr_valid = 1'b1;
        out_ready = 1'b0;
        @(posedge clk);
        #1;
        check(out_port == 6'b000010, "R8 load A", 32'(out_port), 32'h02);
        @(negedge clk);
        put_hdr(VECS[2]);        // child 3
        check(hdr_ready == 1'b0, "R8 ready low in stall", 32'(hdr_ready), 32'd0);
        repeat (2) @(posedge clk);
        #1;
        check(out_valid == 1'b1, "R8 valid held", 32'(out_valid), 32'd1);
        check(out_port == 6'b000010, "R8 port held", 32'(out_port), 32'h02);

        // R9 release: A drains, B loads on the same edge
        @(negedge clk);
        out_ready = 1'b1;
        #0.5;
        check(hdr_ready == 1'b1, "R9 ready with out_ready", 32'(hdr_ready), 32'd1);
        @(posedge clk);
        #1;
        check(out_valid == 1'b1, "R9 no bubble", 32'(out_valid), 32'd1);
        check(out_port == 6'b100000, "R9 B loaded", 32'(out_port), 32'h20);
        @(negedge clk);
        hdr_valid = 1'b0;
        @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R10 final drain", 32'(out_valid), 32'd0);

        // R1 reset mid-stream
        @(negedge clk);
        put_hdr(VECS[0]);
        hdr_valid = 1'b1;
        out_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        hdr_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R1 reset clears", 32'(out_valid), 32'd0);
        check(hdr_ready == 1'b1, "R1 reset ready", 32'(hdr_ready), 32'd1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule